// File: doc/BRIEF.md
# Swap-Mix Keystream Generator

This block produces a pseudorandom keystream, one bit per transfer, for use by a downstream cipher stage. Inside are five maximal-length shift registers. Their lengths are 7, 10, 13, 17 and 19 cells, so each has a different period. Two 2×2 swap stages combine their outputs. The first swap is steered by register 5 and exchanges registers 3 and 4. One of its outputs becomes a data bit. The other output steers a second swap, which exchanges registers 1 and 2. The keystream bit is the XOR of the data bit from the first swap and the selected bit from the second swap.

Seeds are written one register at a time through a 32-bit word, an address and a write strobe. The keystream leaves on a valid/ready pair. `ks_valid` follows `gen_en`. While `ks_valid` is high and `ks_ready` is low, the generator does not move and `ks_bit` is held. All five registers advance together on the cycle in which both are high. The bit shown during that cycle is the one consumed, and it is formed from the register contents before the advance.

Top module: `swapmix_keygen`

## Requirements
- R1: After reset every register holds the value 1 (only cell 0 set), so `ks_bit` is 0 until the first transfer.
- R2: Each register of length L shifts toward its top cell. Cell 0 takes in the XOR of cells k-1, one for each non-constant term x^k of its polynomial. The register's output is cell L-1. The polynomials are x^7+x+1, x^10+x^3+1, x^13+x^4+x^3+x+1, x^17+x^5+1 and x^19+x^5+x^2+x+1, for registers 1 to 5.
- R3: Let s = out5. If s is 0, then a = out3 and b = out4; if s is 1, then a = out4 and b = out3. If b is 0, then c = out1; if b is 1, then c = out2. The keystream bit is a XOR c.
- R4: `ks_valid` equals `gen_en`. All five registers advance exactly on cycles with `ks_valid` and `ks_ready` both high. On every other cycle without a seed write, `ks_bit` stays unchanged.
- R5: A cycle with `seed_we` high and `seed_addr` 0 to 4 loads register `seed_addr`+1 from the low L bits of `seed_data`, visible in the next cycle. Higher bits are discarded.
- R6: If the low L bits of a seed word are all zero, the register is loaded with 1 instead.
- R7: A seed write to address 5, 6 or 7 changes no register.
- R8: If a seed write and a transfer fall in the same cycle, the addressed register takes the seed and the other four advance. The transferred bit comes from the state before that edge.
- R9: Over a long run, the keystream agrees with out1 XOR out4 on roughly 62.5% of transfers. The accepted band is 58% to 67%.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| seed_we | input | 1 | Seed write strobe |
| seed_addr | input | 3 | Register select for a seed write (0..4) |
| seed_data | input | 32 | Seed word, low bits used |
| gen_en | input | 1 | Enables keystream production |
| ks_ready | input | 1 | Consumer accepts the current bit |
| ks_valid | output | 1 | Keystream bit available |
| ks_bit | output | 1 | Current keystream bit |

## Verification
A seed write and a keystream transfer can land on the same clock edge. The bench provokes this by holding `gen_en` and `ks_ready` high while it writes a seed into one register. The bit taken in that cycle must match a model evaluated on the old state. The bits that follow must match a model in which only the addressed register was reloaded and the other four advanced. The same overlap is also exercised under back-pressure: `ks_ready` is held low while a seed is written, so the reload must occur with no advance.

// File: rtl/keygen_pkg.sv
package keygen_pkg;
  localparam int NREG   = 5;
  localparam int MAXLEN = 19;
  localparam int REG_LEN [NREG] = '{7, 10, 13, 17, 19};
  localparam logic [31:0] REG_TAPS [NREG] =
    '{32'h0000_0041, 32'h0000_0204, 32'h0000_100D, 32'h0001_0010, 32'h0004_0013};
  typedef logic [NREG-1:0] regvec_t;
endpackage

// File: rtl/lfsr_fib.sv
module lfsr_fib #(
  parameter int          LEN  = 7,
  parameter logic [31:0] TAPS = 32'h41
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           step,
  input  logic [LEN-1:0] seed,
  output logic           out_bit
);
  localparam logic [LEN-1:0] MASK = TAPS[LEN-1:0];
  localparam logic [LEN-1:0] ONE  = {{(LEN-1){1'b0}}, 1'b1};

  logic [LEN-1:0] st;
  logic           fb;

  assign fb      = ^(st & MASK);
  assign out_bit = st[LEN-1];

  always_ff @(posedge clk) begin
    if (!rst_n)          st <= ONE;
    else if (load)       st <= (seed == '0) ? ONE : seed;
    else if (step)       st <= {st[LEN-2:0], fb};
  end

  // R2
  nonzero_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st != '0);
  // R2
  shift_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (st[LEN-1:1] == $past(st[LEN-2:0])));
  // R6
  zero_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && seed == '0) |=> (st == ONE));
  // R5
  seed_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && seed != '0) |=> (st == $past(seed)));
  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> $stable(st));
endmodule

// File: rtl/swap2.sv
module swap2 (
  input  logic sel,
  input  logic in0,
  input  logic in1,
  output logic out0,
  output logic out1
);
  assign out0 = sel ? in1 : in0;
  assign out1 = sel ? in0 : in1;

  always_comb begin
    if (!$isunknown({sel, in0, in1})) begin
      // R3
      swap_keep_chk: assert ($countones({out0, out1}) == $countones({in0, in1}));
    end
  end
endmodule

// File: rtl/swapmix_keygen.sv
module swapmix_keygen
  import keygen_pkg::*;
#(
  parameter int SEED_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seed_we,
  input  logic [ADDR_W-1:0] seed_addr,
  input  logic [SEED_W-1:0] seed_data,
  input  logic              gen_en,
  input  logic              ks_ready,
  output logic              ks_valid,
  output logic              ks_bit
);
  regvec_t lout;
  logic    xfer;
  logic    direct_bit, ctl_bit, mix_bit, spare_bit;

  assign ks_valid = gen_en;
  assign xfer     = ks_valid && ks_ready;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic ld;
    assign ld = seed_we && (seed_addr == ADDR_W'(g));
    lfsr_fib #(.LEN(REG_LEN[g]), .TAPS(REG_TAPS[g])) u_lfsr (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (ld),
      .step    (xfer),
      .seed    (seed_data[REG_LEN[g]-1:0]),
      .out_bit (lout[g])
    );
  end

  swap2 u_swap_hi (
    .sel (lout[4]), .in0 (lout[2]), .in1 (lout[3]),
    .out0(direct_bit), .out1(ctl_bit)
  );
  swap2 u_swap_lo (
    .sel (ctl_bit), .in0 (lout[0]), .in1 (lout[1]),
    .out0(mix_bit), .out1(spare_bit)
  );

  assign ks_bit = direct_bit ^ mix_bit;

  // R4
  ks_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer && !seed_we) |=> $stable(ks_bit));
  // R3
  low_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mix_bit ^ spare_bit) == (lout[0] ^ lout[1]));
  // R5
  seed_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seed_we |-> !$isunknown({seed_addr, seed_data}));
endmodule

// File: tb/swapmix_keygen_tb_top.sv
`timescale 1ns/1ps
module swapmix_keygen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        seed_we = 1'b0;
  logic [2:0]  seed_addr = '0;
  logic [31:0] seed_data = '0;
  logic        gen_en = 1'b0;
  logic        ks_ready = 1'b0;
  logic        ks_valid, ks_bit;

  int checks = 0;
  int errors = 0;
  int agree = 0;
  int total = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  swapmix_keygen dut_i (
    .clk(clk), .rst_n(rst_n), .seed_we(seed_we), .seed_addr(seed_addr),
    .seed_data(seed_data), .gen_en(gen_en), .ks_ready(ks_ready),
    .ks_valid(ks_valid), .ks_bit(ks_bit)
  );

  int          mlen [5] = '{7, 10, 13, 17, 19};
  logic [31:0] mtap [5] = '{32'h41, 32'h204, 32'h100D, 32'h10010, 32'h40013};
  logic [31:0] mst  [5];

  localparam logic [31:0] SEED_TAB [4][5] = '{
    '{32'h0000_0055, 32'h0000_0301, 32'h0000_1ABC, 32'h0001_2345, 32'h0007_FFFF},
    '{32'hFFFF_FF7F, 32'hDEAD_BEEF, 32'h1234_5678, 32'hCAFE_F00D, 32'h8765_4321},
    '{32'h0000_0001, 32'h0000_0200, 32'h0000_0F0F, 32'h0000_AAAA, 32'h0005_5555},
    '{32'h0000_0040, 32'h0000_03FF, 32'h0000_1000, 32'h0001_FFFF, 32'h0004_0000}
  };

  function automatic logic mout(int i);
    return mst[i][mlen[i]-1];
  endfunction

  function automatic logic model_ks();
    logic a, b, c;
    a = mout(4) ? mout(3) : mout(2);
    b = mout(4) ? mout(2) : mout(3);
    c = b ? mout(1) : mout(0);
    return a ^ c;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 5; i++) mst[i] = 32'd1;
  endtask

  task automatic chk(input logic ok, input string tag, input logic act, input logic exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // One cycle: check the current bit at the falling edge, drive, then track the edge in the model.
  task automatic do_cycle(input logic e, input logic r, input logic w,
                          input logic [2:0] a, input logic [31:0] d, input string tag);
    logic exp, fb;
    logic [31:0] msk, v;
    @(negedge clk);
    exp = model_ks();
    chk(ks_bit === exp, tag, ks_bit, exp);
    total++;
    if (ks_bit == (mout(0) ^ mout(3))) agree++;
    gen_en = e; ks_ready = r; seed_we = w; seed_addr = a; seed_data = d;
    @(posedge clk);
    for (int i = 0; i < 5; i++) begin
      msk = (32'd1 << mlen[i]) - 32'd1;
      if (w && a == 3'(i)) begin
        v = d & msk;
        mst[i] = (v == 0) ? 32'd1 : v;
      end else if (e && r) begin
        fb = ^(mst[i] & mtap[i]);
        mst[i] = ((mst[i] << 1) | {31'd0, fb}) & msk;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset state and the run that follows from it
    do_cycle(1'b0, 1'b0, 1'b0, 3'd0, 32'd0, "R1");
    for (int k = 0; k < 40; k++) do_cycle(1'b1, 1'b1, 1'b0, 3'd0, 32'd0, "R1");

    // R2 R3: table walk, seeds then a run with ready gaps
    for (int row = 0; row < 4; row++) begin
      for (int i = 0; i < 5; i++) do_cycle(1'b0, 1'b0, 1'b1, 3'(i), SEED_TAB[row][i], "R5");
      for (int k = 0; k < 60; k++) do_cycle(1'b1, (k % 3) != 2, 1'b0, 3'd0, 32'd0, "R2 R3");
    end

    // R4: back-pressure and disable both hold the bit
    @(negedge clk); gen_en = 1'b1; ks_ready = 1'b0; #1;
    chk(ks_valid === 1'b1, "R4", ks_valid, 1'b1);
    gen_en = 1'b0; #1;
    chk(ks_valid === 1'b0, "R4", ks_valid, 1'b0);
    for (int k = 0; k < 6; k++) do_cycle(1'b1, 1'b0, 1'b0, 3'd0, 32'd0, "R4");
    for (int k = 0; k < 6; k++) do_cycle(1'b0, 1'b1, 1'b0, 3'd0, 32'd0, "R4");
    for (int k = 0; k < 10; k++) do_cycle(1'b1, 1'b1, 1'b0, 3'd0, 32'd0, "R4");

    // R6: zero low bits with upper garbage
    do_cycle(1'b0, 1'b0, 1'b1, 3'd0, 32'hFFFF_FF80, "R6");
    do_cycle(1'b0, 1'b0, 1'b1, 3'd4, 32'hFFF8_0000, "R6");
    for (int k = 0; k < 30; k++) do_cycle(1'b1, 1'b1, 1'b0, 3'd0, 32'd0, "R6");

    // R7: out-of-range addresses
    do_cycle(1'b0, 1'b0, 1'b1, 3'd5, 32'h0000_0000, "R7");
    do_cycle(1'b0, 1'b0, 1'b1, 3'd6, 32'h1234_5678, "R7");
    do_cycle(1'b0, 1'b0, 1'b1, 3'd7, 32'hFFFF_FFFF, "R7");
    for (int k = 0; k < 30; k++) do_cycle(1'b1, 1'b1, 1'b0, 3'd0, 32'd0, "R7");

    // R8: seed write on a transfer cycle, and under back-pressure
    do_cycle(1'b1, 1'b1, 1'b1, 3'd2, 32'h0000_0ACE, "R8");
    do_cycle(1'b1, 1'b1, 1'b1, 3'd4, 32'h0000_0001, "R8");
    do_cycle(1'b1, 1'b0, 1'b1, 3'd1, 32'h0000_0155, "R8");
    for (int k = 0; k < 30; k++) do_cycle(1'b1, 1'b1, 1'b0, 3'd0, 32'd0, "R8");

    // R9: correlation with out1 XOR out4
    agree = 0; total = 0;
    for (int k = 0; k < 4000; k++) do_cycle(1'b1, 1'b1, 1'b0, 3'd0, 32'd0, "R9");
    checks++;
    if (agree * 1000 < total * 580 || agree * 1000 > total * 670) begin
      errors++;
      $display("FAIL R9 actual=%0d/%0d expected about 625/1000", agree, total);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule